// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block turns a bit-per-dot display image into a 2-bit drive-level code on every pin of a multiplexed LCD panel. It scans the active commons one slot at a time, drives the scanned common to an extreme bias level and the others to a middle level, and drives each segment to the opposite extreme when its dot is lit or to a near-middle level when it is dark. It inverts every level after each full frame so that the panel sees no DC component. An analog stage outside this block turns the codes into voltages.

The pin row has two common-only pins, then shared pins that act as commons or segments depending on the programmed duty, then segment-only pins. Fewer commons therefore give more segments. A timebase strobe from the low-speed clock domain paces the scan. A rate selector sets how many strobes each common slot lasts, which gives four frame rates. A mode input selects stopped drive, normal display, forced all-lit or forced all-dark.

Top module: `lcd_mux_drive`

## Requirements
- R1: In stop mode (mode code 0) every pin carries code 0 (VSS) and the scan is held at common 0 with positive polarity. Synchronous reset puts the scan in the same state.
- R2: Duty code d selects d+1 active commons. Codes at or above N_COM-1 select N_COM commons. The scan visits commons 0 to n-1 in order and then wraps to 0.
- R3: Each common slot lasts SLOT_MIN + SLOT_STEP*(3 - rate_sel) base_tick strobes. The scan does not advance on cycles without a strobe.
- R4: Polarity toggles when the last active common's slot ends, and every pin level then inverts.
- R5: With one-third bias (bias_third=1), codes are 0=VSS, 1=VL1, 2=VL2, 3=VL3. In positive polarity: scanned common 3, other commons 1, lit segment 0, dark segment 2. In negative polarity: scanned common 0, other commons 2, lit segment 3, dark segment 1.
- R6: With half bias (bias_third=0), every middle level is code 2 and code 1 never appears. The extremes follow R5.
- R7: Pins 0 and 1 are always commons 0 and 1. Pin k for 2<=k<N_COM is common k when k is below the active count, otherwise segment k-2. Pin p>=N_COM is segment p-2.
- R8: A common pin whose index is at or above the active count is held at the unscanned common level.
- R9: In all-lit mode (code 2) every segment pin takes the lit level while the common scan keeps running.
- R10: In all-dark mode (code 3) every segment pin takes the dark level while the common scan keeps running.
- R11: In normal mode (code 1) segment s while common c is scanned is lit when disp_bits[c*N_SEG+s] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | Timebase strobe, one cycle wide |
| mode | input | 2 | 0 stop, 1 normal, 2 all-lit, 3 all-dark |
| duty_sel | input | $clog2(N_COM) | Active commons minus one |
| bias_third | input | 1 | 1 = one-third bias, 0 = half bias |
| rate_sel | input | 2 | Frame rate select, higher is faster |
| disp_bits | input | N_COM*N_SEG | Dot image, common-major |
| pin_code | output | 2*(N_SEG+2) | Level code per pin, pin p at bits 2p+1:2p |

## Verification
The bench builds the block at its default of five commons and twenty-two segments, with a shortest slot of two strobes and a step of one. At that size every shared pin can be seen in both roles, and the single-common case leaves a dedicated common pin unused. A behavioural model of the scan position and polarity predicts all 24 pin codes on every clock. The bench covers every duty code including the clamped ones, both biases, all four rates with sparse and dense strobes, and every mode. This brings many polarity flips and the transitions into and out of stop within reach.

// File: rtl/lcd_seq_pkg.sv
// Shared types and level functions for the LCD sequencer.
// Assumes a 2-bit code per pin: 0=VSS, 1=VL1, 2=VL2, 3=VL3.
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_STOP    = 2'd0,
        MODE_SHOW    = 2'd1,
        MODE_ALL_ON  = 2'd2,
        MODE_ALL_OFF = 2'd3
    } drive_mode_e;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_VSS = 2'd0;
    localparam lvl_t LV_1   = 2'd1;
    localparam lvl_t LV_2   = 2'd2;
    localparam lvl_t LV_3   = 2'd3;

    // Level of a common pin for scan state, polarity and bias.
    function automatic lvl_t com_level(input logic scanned, input logic pol,
                                       input logic third);
        if (scanned) return pol ? LV_VSS : LV_3;
        if (!third)  return LV_2;
        return pol ? LV_2 : LV_1;
    endfunction

    // Level of a segment pin for dot state, polarity and bias.
    function automatic lvl_t seg_level(input logic lit, input logic pol,
                                       input logic third);
        if (lit)    return pol ? LV_3 : LV_VSS;
        if (!third) return LV_2;
        return pol ? LV_1 : LV_2;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
// Slot timer and common scanner.
// Counts base_tick strobes per common slot, walks the active commons and
// flips polarity at each frame end. Held at common 0, positive polarity,
// while run is low or reset is asserted. Assumes SLOT_MIN >= 1.
module lcd_scan_timer #(
    parameter int N_COM     = 5,
    parameter int SLOT_MIN  = 2,
    parameter int SLOT_STEP = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       base_tick,
    input  logic [1:0]                 rate_sel,
    input  logic [$clog2(N_COM+1)-1:0] n_act,
    output logic [$clog2(N_COM)-1:0]   com_idx,
    output logic                       pol,
    output logic                       frame_end
);
    localparam int SL_MAX = SLOT_MIN + 3 * SLOT_STEP;
    localparam int SW     = $clog2(SL_MAX + 1);

    logic [SW-1:0] slot_cnt;
    logic [SW-1:0] slot_len;
    logic          slot_last;
    logic          com_last;

    assign slot_len  = SW'(SLOT_MIN + SLOT_STEP * (3 - int'(rate_sel)));
    assign slot_last = (slot_cnt >= slot_len - SW'(1));
    assign com_last  = (int'(com_idx) >= int'(n_act) - 1);
    assign frame_end = run & base_tick & slot_last & com_last;

    // Advance slot counter, common index and polarity on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot_cnt <= '0;
            com_idx  <= '0;
            pol      <= 1'b0;
        end else if (base_tick) begin
            if (slot_last) begin
                slot_cnt <= '0;
                if (com_last) begin
                    com_idx <= '0;
                    pol     <= ~pol;
                end else begin
                    com_idx <= com_idx + 1'b1;
                end
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_pin_map.sv
// Pin role decode and level mapping.
// Pins 0 and 1 are commons. Pins 2..N_COM-1 are commons when active and
// segments otherwise. The remaining pins are segments. Pure combinational.
// Assumes N_COM >= 3.
module lcd_pin_map
    import lcd_seq_pkg::*;
#(
    parameter int N_COM = 5,
    parameter int N_SEG = 22
) (
    input  logic [$clog2(N_COM)-1:0]     com_idx,
    input  logic                         pol,
    input  logic                         third,
    input  drive_mode_e                  mode,
    input  logic [$clog2(N_COM+1)-1:0]   n_act,
    input  logic [N_COM-1:0][N_SEG-1:0]  disp,
    output logic [N_SEG+1:0][1:0]        pins
);
    localparam int N_PIN = N_SEG + 2;

    logic             stop;
    logic [N_SEG-1:0] seg_on;

    assign stop = (mode == MODE_STOP);

    // Pick the dot row of the scanned common, or a forced pattern.
    always_comb begin
        case (mode)
            MODE_ALL_ON:  seg_on = '1;
            MODE_ALL_OFF: seg_on = '0;
            default:      seg_on = disp[com_idx];
        endcase
    end

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        if (p < 2) begin : g_com
            assign pins[p] = stop ? LV_VSS :
                com_level((int'(n_act) > p) && (int'(com_idx) == p), pol, third);
        end else if (p < N_COM) begin : g_shared
            logic as_com;
            assign as_com  = (int'(n_act) > p);
            assign pins[p] = stop ? LV_VSS :
                as_com ? com_level(int'(com_idx) == p, pol, third)
                       : seg_level(seg_on[p-2], pol, third);
        end else begin : g_seg
            assign pins[p] = stop ? LV_VSS : seg_level(seg_on[p-2], pol, third);
        end
    end
endmodule

// File: rtl/lcd_mux_drive.sv
// Top of the multiplexed LCD sequencer.
// Decodes the duty code into an active common count, runs the scan timer
// and maps every pin to a level code. Outputs follow the scan registers
// and the inputs combinationally.
module lcd_mux_drive
    import lcd_seq_pkg::*;
#(
    parameter int N_COM     = 5,
    parameter int N_SEG     = 22,
    parameter int SLOT_MIN  = 2,
    parameter int SLOT_STEP = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        base_tick,
    input  logic [1:0]                  mode,
    input  logic [$clog2(N_COM)-1:0]    duty_sel,
    input  logic                        bias_third,
    input  logic [1:0]                  rate_sel,
    input  logic [N_COM*N_SEG-1:0]      disp_bits,
    output logic [2*(N_SEG+2)-1:0]      pin_code
);
    localparam int CW = $clog2(N_COM + 1);
    localparam int IW = $clog2(N_COM);

    drive_mode_e                 mode_e;
    logic [CW-1:0]               n_act;
    logic [IW-1:0]               com_idx;
    logic                        pol;
    logic                        frame_end;
    logic [N_COM-1:0][N_SEG-1:0] disp_rows;
    logic [N_SEG+1:0][1:0]       pins;

    assign mode_e    = drive_mode_e'(mode);
    assign disp_rows = disp_bits;
    assign pin_code  = pins;

    // Active common count: duty code plus one, clamped to N_COM.
    always_comb begin
        if (int'(duty_sel) >= N_COM - 1) n_act = CW'(N_COM);
        else                             n_act = CW'(int'(duty_sel) + 1);
    end

    lcd_scan_timer #(
        .N_COM(N_COM), .SLOT_MIN(SLOT_MIN), .SLOT_STEP(SLOT_STEP)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(mode_e != MODE_STOP),
        .base_tick(base_tick), .rate_sel(rate_sel), .n_act(n_act),
        .com_idx(com_idx), .pol(pol), .frame_end(frame_end)
    );

    lcd_pin_map #(.N_COM(N_COM), .N_SEG(N_SEG)) u_map (
        .com_idx(com_idx), .pol(pol), .third(bias_third), .mode(mode_e),
        .n_act(n_act), .disp(disp_rows), .pins(pins)
    );
endmodule

// File: rtl/lcd_mux_drive_chk.sv
// Checker for lcd_mux_drive, bound to every instance of the top.
// Assumes duty_sel changes only while the scan is stopped or the
// scanned index lies inside the active range (guarded below).
module lcd_mux_drive_chk #(
    parameter int N_COM = 5,
    parameter int N_SEG = 22
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       base_tick,
    input logic [1:0]                 mode,
    input logic [$clog2(N_COM)-1:0]   duty_sel,
    input logic                       bias_third,
    input logic [2*(N_SEG+2)-1:0]     pin_code,
    input logic [$clog2(N_COM)-1:0]   com_idx,
    input logic                       pol,
    input logic                       frame_end
);
    localparam int N_PIN = N_SEG + 2;

    int          ncom;
    int          n_extreme;
    logic        any_vl1;

    // Active commons and count of common pins at an extreme level.
    always_comb begin
        ncom = (int'(duty_sel) >= N_COM - 1) ? N_COM : int'(duty_sel) + 1;
        n_extreme = 0;
        for (int k = 0; k < N_COM; k++) begin
            if (k < ncom && (pin_code[2*k +: 2] == 2'd0 || pin_code[2*k +: 2] == 2'd3))
                n_extreme = n_extreme + 1;
        end
        any_vl1 = 1'b0;
        for (int k = 0; k < N_PIN; k++) begin
            if (pin_code[2*k +: 2] == 2'd1) any_vl1 = 1'b1;
        end
    end

    AST_STOP_ALL_VSS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (pin_code == '0)); // R1

    AST_ONE_SCANNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && int'(com_idx) < ncom) |-> (n_extreme == 1)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !base_tick) |=> $stable(com_idx)); // R3

    AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pol != $past(pol))); // R4

    AST_HALF_NO_VL1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_third) |-> !any_vl1); // R6

    AST_UNUSED_COM_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && ncom == 1) |-> (pin_code[3:2] == 2'd1 || pin_code[3:2] == 2'd2)); // R8
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .mode(mode),
    .duty_sel(duty_sel), .bias_third(bias_third), .pin_code(pin_code),
    .com_idx(com_idx), .pol(pol), .frame_end(frame_end)
);

// File: tb/sim_lcd_mux_drive.sv
// Bench for lcd_mux_drive: behavioural scan model compared every clock.
module sim_lcd_mux_drive;
    localparam int N_COM = 5;
    localparam int N_SEG = 22;
    localparam int SLOT_MIN = 2;
    localparam int SLOT_STEP = 1;
    localparam int N_PIN = N_SEG + 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     base_tick = 1'b0;
    logic [1:0]               mode = 2'd1;
    logic [2:0]               duty_sel = 3'd4;
    logic                     bias_third = 1'b1;
    logic [1:0]               rate_sel = 2'd3;
    logic [N_COM*N_SEG-1:0]   disp_bits = '0;
    logic [2*N_PIN-1:0]       pin_code;

    int total = 0;
    int bad = 0;
    int m_slot = 0;
    int m_com = 0;
    int m_pol = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lcd_mux_drive #(.N_COM(N_COM), .N_SEG(N_SEG), .SLOT_MIN(SLOT_MIN),
                    .SLOT_STEP(SLOT_STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .mode(mode),
        .duty_sel(duty_sel), .bias_third(bias_third), .rate_sel(rate_sel),
        .disp_bits(disp_bits), .pin_code(pin_code)
    );

    function automatic int active_n();
        return (int'(duty_sel) >= N_COM - 1) ? N_COM : int'(duty_sel) + 1;
    endfunction

    // Reference scan state, advanced on the rising edge.
    always @(posedge clk) begin
        if (!rst_n || mode == 2'd0) begin
            m_slot = 0; m_com = 0; m_pol = 0;
        end else if (base_tick) begin
            int len;
            len = SLOT_MIN + SLOT_STEP * (3 - int'(rate_sel));
            m_slot = m_slot + 1;
            if (m_slot == len) begin
                m_slot = 0;
                m_com = m_com + 1;
                if (m_com == active_n()) begin
                    m_com = 0;
                    m_pol = 1 - m_pol;
                end
            end
        end
    end

    // Expected code of one pin from the requirements.
    function automatic int expect_pin(int p);
        int n;
        bit is_com, sel, lit;
        if (mode == 2'd0) return 0;
        n = active_n();
        is_com = (p < 2) || (p < N_COM && p < n);
        if (is_com) begin
            sel = (p < n) && (p == m_com);
            if (sel) return (m_pol == 1) ? 0 : 3;
            if (!bias_third) return 2;
            return (m_pol == 1) ? 2 : 1;
        end
        if (mode == 2'd2) lit = 1'b1;
        else if (mode == 2'd3) lit = 1'b0;
        else lit = disp_bits[m_com * N_SEG + (p - 2)];
        if (lit) return (m_pol == 1) ? 3 : 0;
        if (!bias_third) return 2;
        return (m_pol == 1) ? 1 : 2;
    endfunction

    task automatic check_all();
        total++;
        for (int p = 0; p < N_PIN; p++) begin
            int got, want;
            got = int'(pin_code[2*p +: 2]);
            want = expect_pin(p);
            if (got != want) begin
                bad++;
                $display("FAIL %s pin %0d actual %0d expected %0d", cur_req, p, got, want);
                break;
            end
        end
    endtask

    task automatic check_one(string req, int p, int want);
        int got;
        total++;
        got = int'(pin_code[2*p +: 2]);
        if (got != want) begin
            bad++;
            $display("FAIL %s pin %0d actual %0d expected %0d", req, p, got, want);
        end
    endtask

    // Run n cycles with a strobe every k cycles, comparing every clock.
    task automatic run(int n, int k);
        for (int i = 0; i < n; i++) begin
            base_tick = ((i % k) == 0);
            @(negedge clk);
            check_all();
        end
        base_tick = 1'b0;
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < N_COM*N_SEG; i++)
            disp_bits[i] = (((i * 7 + seed) % 5) < 2);
    endtask

    task automatic to_stop();
        mode = 2'd0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fill(3);
        @(negedge clk);
        @(negedge clk);
        // R1: reset holds common 0 scanned, positive polarity
        cur_req = "R1";
        check_one("R1", 0, 3);
        check_one("R1", 1, 1);
        rst_n = 1'b1;
        mode = 2'd0;
        run(10, 1);
        for (int p = 0; p < N_PIN; p++) begin
            if (p == 0 || p == 7 || p == 23) check_one("R1", p, 0);
        end

        // R5 R11 R4 R2: normal drive, five commons, one-third bias
        cur_req = "R5/R11/R4/R2";
        mode = 2'd1; duty_sel = 3'd4; rate_sel = 2'd3;
        run(120, 1);
        fill(1);
        run(60, 2);

        // R7 R8 R2: each duty code, including clamped ones
        for (int d = 0; d < 8; d++) begin
            to_stop();
            duty_sel = 3'(d);
            mode = 2'd1;
            cur_req = (d == 0) ? "R8/R7" : "R2/R7";
            run(80, 1);
        end

        // R6: half bias
        to_stop();
        duty_sel = 3'd2; bias_third = 1'b0; mode = 2'd1;
        cur_req = "R6";
        run(100, 1);
        bias_third = 1'b1;

        // R3: every rate with sparse strobes
        for (int r = 0; r < 4; r++) begin
            to_stop();
            rate_sel = 2'(r); duty_sel = 3'd3; mode = 2'd1;
            cur_req = "R3";
            run(120, 3);
        end

        // R9: all segments lit, scan continues
        cur_req = "R9";
        mode = 2'd2;
        run(80, 1);
        check_one("R9", 10, (m_pol == 1) ? 3 : 0);

        // R10: all segments dark
        cur_req = "R10";
        mode = 2'd3; bias_third = 1'b0;
        run(60, 1);
        check_one("R10", 10, 2);
        bias_third = 1'b1;
        run(40, 1);

        // R1: stop from a running scan
        cur_req = "R1";
        mode = 2'd0;
        run(5, 1);
        mode = 2'd1;
        run(20, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual %0d expected %0d", cyc_cnt, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule